// File: doc/BRIEF.md
# Zero-Suppressing Strip Data Formatter

This block sits behind pedestal correction in a silicon-strip readout chain. It receives one pedestal-corrected amplitude per cycle, each tagged with a strip index, and turns the stream into 32-bit words for the next stage. Two output formats are available. Sparse mode drops quiet strips on the fly and gives each surviving strip its own word with its address inside. Dense mode keeps every strip and packs three amplitudes per word. In dense mode a value's slot and word position alone identify the strip.

An event is framed by a first-strip flag and a final-strip flag on the input. The format and threshold are taken from the configuration input on the first strip and held for the rest of the event. The word that closes an event carries an end-of-event flag. Both sides use valid/ready handshakes. The input is held off whenever the output register cannot take a new word, so no strip is lost.

Top module: `zs_strip_formatter`

## Requirements
- R1: After reset, out_valid and out_eoe are low and in_ready is high.
- R2: In sparse mode (cfg_sparse = 1) a strip produces a word only when its amplitude is strictly greater than the threshold. A strip equal to the threshold is dropped. With threshold 0, every nonzero strip is kept.
- R3: A sparse word holds the amplitude in bits [9:0] and the 14-bit strip index in bits [23:10]. Bits [31:24] are zero.
- R4: In dense mode (cfg_sparse = 0) the slots are filled in order. The first strip of each group of three goes to bits [9:0], the second to [19:10] and the third to [29:20]. Bits [31:30] are zero.
- R5: If a dense event ends with a partly filled word, that word is still sent with its unused slots at zero and with out_eoe set.
- R6: out_eoe is high on exactly the last word of each event that had its final strip marked, and on no other word. In sparse mode the last kept strip is held back so that it can carry the flag.
- R7: A sparse event in which no strip passes produces a single all-zero word with out_eoe set.
- R8: While out_valid is high and out_ready is low, out_data and out_eoe stay stable and in_ready is low. No word and no strip is lost under any pattern of out_ready.
- R9: cfg_sparse and cfg_thr are sampled with the first strip of an event. Changes to them later in the same event have no effect on that event's words.
- R10: A first-strip flag discards any unfinished word left over from an event that never received its final strip. Words already emitted by that event are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sparse | input | 1 | Format select: 1 = sparse, 0 = dense; sampled on the first strip |
| cfg_thr | input | 10 | Sparse threshold; sampled on the first strip |
| in_valid | input | 1 | A strip is presented |
| in_ready | output | 1 | The strip is accepted this cycle if valid |
| in_sof | input | 1 | Strip is the first of an event |
| in_last | input | 1 | Strip is the last of an event |
| in_amp | input | 10 | Corrected strip amplitude |
| in_idx | input | 14 | Strip index |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Formatted word |
| out_eoe | output | 1 | Word closes its event |

## Verification
Two situations can fall in the same cycle and are checked on purpose.

The first is in sparse mode, when the final strip of an event is kept while an earlier kept strip is still held back. The held word has to leave in that same cycle, and the new strip becomes the pending word that later carries the end flag.

The second is a dense final strip that completes a word. Completion and end-of-event then coincide, and no separate flush is needed.

Both cases come from amplitude patterns chosen against the threshold. They are run once with a consumer that is always ready and once with a pseudo-random stall pattern on out_ready. A scoreboard built from the requirements predicts every word and its end flag, and each stalled cycle is checked for a stable output.

// File: rtl/zsf_pkg.sv
package zsf_pkg;
    typedef enum logic {
        FMT_DENSE  = 1'b0,
        FMT_SPARSE = 1'b1
    } fmt_e;
endpackage

// File: rtl/zsf_keep.sv
module zsf_keep #(
    parameter int AMP_W = 10
) (
    input  logic [AMP_W-1:0] amp,
    input  logic [AMP_W-1:0] thr,
    output logic             keep
);
    // strict comparison: a strip at the threshold is dropped
    assign keep = (amp > thr);
endmodule

// File: rtl/zsf_sparse_word.sv
module zsf_sparse_word #(
    parameter int AMP_W  = 10,
    parameter int IDX_W  = 14,
    parameter int WORD_W = 32
) (
    input  logic [AMP_W-1:0]  amp,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    localparam int PAD_W = WORD_W - IDX_W - AMP_W;

    assign word = {{PAD_W{1'b0}}, idx, amp};
endmodule

// File: rtl/zsf_slot_insert.sv
module zsf_slot_insert #(
    parameter int AMP_W  = 10,
    parameter int WORD_W = 32,
    parameter int SLOTS  = 3,
    parameter int CNT_W  = 2
) (
    input  logic [WORD_W-1:0] base,
    input  logic [CNT_W-1:0]  slot,
    input  logic [AMP_W-1:0]  amp,
    output logic [WORD_W-1:0] word
);
    localparam int PACK_W = SLOTS * AMP_W;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign word[s*AMP_W +: AMP_W] = (slot == CNT_W'(s)) ? amp : base[s*AMP_W +: AMP_W];
    end

    if (WORD_W > PACK_W) begin : g_pad
        assign word[WORD_W-1:PACK_W] = base[WORD_W-1:PACK_W];
    end
endmodule

// File: rtl/zs_strip_formatter.sv
module zs_strip_formatter
    import zsf_pkg::*;
#(
    parameter int AMP_W  = 10,
    parameter int IDX_W  = 14,
    parameter int WORD_W = 32,
    parameter int SLOTS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sparse,
    input  logic [AMP_W-1:0]  cfg_thr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic              in_last,
    input  logic [AMP_W-1:0]  in_amp,
    input  logic [IDX_W-1:0]  in_idx,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_eoe
);
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

    typedef struct packed {
        logic              out_valid;
        logic              out_eoe;
        logic [WORD_W-1:0] out_data;
        logic [WORD_W-1:0] acc_data;
        logic              acc_valid;
        logic [CNT_W-1:0]  acc_cnt;
        logic              flush;
        fmt_e              mode;
        logic [AMP_W-1:0]  thr;
    } state_t;

    state_t st_q, st_d;

    logic              space, fire, keep;
    fmt_e              eff_mode;
    logic [AMP_W-1:0]  eff_thr;
    logic [WORD_W-1:0] base_data, sparse_word, dense_word;
    logic              base_valid;
    logic [CNT_W-1:0]  base_cnt;

    // an opening strip uses live configuration and starts from an empty word
    assign eff_mode   = in_sof ? fmt_e'(cfg_sparse) : st_q.mode;
    assign eff_thr    = in_sof ? cfg_thr : st_q.thr;
    assign base_data  = in_sof ? '0 : st_q.acc_data;
    assign base_valid = in_sof ? 1'b0 : st_q.acc_valid;
    assign base_cnt   = in_sof ? '0 : st_q.acc_cnt;

    assign space    = !st_q.out_valid || out_ready;
    assign in_ready = space && !st_q.flush;
    assign fire     = in_valid && in_ready;

    zsf_keep #(.AMP_W(AMP_W)) u_keep (
        .amp  (in_amp),
        .thr  (eff_thr),
        .keep (keep)
    );

    zsf_sparse_word #(.AMP_W(AMP_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_sparse (
        .amp  (in_amp),
        .idx  (in_idx),
        .word (sparse_word)
    );

    zsf_slot_insert #(.AMP_W(AMP_W), .WORD_W(WORD_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_ins (
        .base (base_data),
        .slot (base_cnt),
        .amp  (in_amp),
        .word (dense_word)
    );

    always_comb begin
        st_d = st_q;
        if (space) begin
            st_d.out_valid = 1'b0;
            st_d.out_eoe   = 1'b0;
        end

        if (st_q.flush && space) begin
            // close the event with whatever the accumulator holds
            st_d.out_valid = 1'b1;
            st_d.out_eoe   = 1'b1;
            st_d.out_data  = st_q.acc_valid ? st_q.acc_data : '0;
            st_d.acc_data  = '0;
            st_d.acc_valid = 1'b0;
            st_d.acc_cnt   = '0;
            st_d.flush     = 1'b0;
        end else if (fire) begin
            if (in_sof) begin
                st_d.mode = fmt_e'(cfg_sparse);
                st_d.thr  = cfg_thr;
            end
            st_d.acc_data  = base_data;
            st_d.acc_valid = base_valid;
            st_d.acc_cnt   = base_cnt;

            if (eff_mode == FMT_SPARSE) begin
                if (keep) begin
                    if (base_valid) begin
                        st_d.out_valid = 1'b1;
                        st_d.out_eoe   = 1'b0;
                        st_d.out_data  = base_data;
                    end
                    st_d.acc_data  = sparse_word;
                    st_d.acc_valid = 1'b1;
                end
                st_d.flush = in_last;
            end else begin
                if (base_cnt == LAST_SLOT) begin
                    st_d.out_valid = 1'b1;
                    st_d.out_eoe   = in_last;
                    st_d.out_data  = dense_word;
                    st_d.acc_data  = '0;
                    st_d.acc_valid = 1'b0;
                    st_d.acc_cnt   = '0;
                end else begin
                    st_d.acc_data  = dense_word;
                    st_d.acc_valid = 1'b1;
                    st_d.acc_cnt   = base_cnt + 1'b1;
                    st_d.flush     = in_last;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_eoe   = st_q.out_eoe;
    assign out_data  = st_q.out_data;
endmodule

// File: rtl/zsf_checker.sv
module zsf_checker #(
    parameter int AMP_W  = 10,
    parameter int WORD_W = 32,
    parameter int SLOTS  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_eoe
);
    localparam int PACK_W = SLOTS * AMP_W;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eoe)));

    p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_eoe_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoe |-> out_valid);

    p_top_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[WORD_W-1:PACK_W] == '0));
endmodule

bind zs_strip_formatter zsf_checker #(
    .AMP_W(AMP_W), .WORD_W(WORD_W), .SLOTS(SLOTS)
) u_zsf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eoe   (out_eoe)
);

// File: tb/tb_zs_strip_formatter.sv
`timescale 1ns/1ps
module tb_zs_strip_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sparse = 1'b0;
    logic [9:0]  cfg_thr = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sof = 1'b0;
    logic        in_last = 1'b0;
    logic [9:0]  in_amp = '0;
    logic [13:0] in_idx = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_eoe;

    always #2.5 clk = ~clk;

    zs_strip_formatter dut (
        .clk(clk), .rst_n(rst_n), .cfg_sparse(cfg_sparse), .cfg_thr(cfg_thr),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_last(in_last),
        .in_amp(in_amp), .in_idx(in_idx), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_eoe(out_eoe)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];
    bit          bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          prev_stall = 1'b0;
    logic [32:0] prev_word = '0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // consumer stall pattern, changed away from the sampling edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // monitor: compare each handshaken word, and stability during stalls (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && {out_eoe, out_data} == prev_word, "R8 stall stability",
                      {out_eoe, out_data}, prev_word);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected word", {out_eoe, out_data}, '0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_eoe, out_data} == e, t, {out_eoe, out_data}, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_word  = {out_eoe, out_data};
        end
    end

    function automatic int amp_of(input int seed, input int i, input int thr);
        int a;
        case (i % 4)
            0: a = thr;
            1: a = thr + 1;
            2: a = (seed * 53 + i * 97) % 1024;
            default: a = 0;
        endcase
        if (a > 1023) a = 1023;
        return a;
    endfunction

    task automatic run_event(input bit sparse, input int thr, input int n, input int first_idx,
                             input int seed, input bit has_last, input bit flip_cfg, input string tag);
        logic [31:0] pw = '0;
        bit          pend = 1'b0;
        logic [31:0] acc = '0;
        int          cnt = 0;
        // expected words from the requirements
        for (int i = 0; i < n; i++) begin
            int a;
            int idx;
            a = amp_of(seed, i, thr);
            idx = (first_idx + i) % 16384;
            if (sparse) begin
                if (a > thr) begin
                    if (pend) begin exp_q.push_back({1'b0, pw}); tag_q.push_back(tag); end
                    pw = {8'h00, 14'(idx), 10'(a)};
                    pend = 1'b1;
                end
            end else begin
                acc = acc | (32'(a) << (10 * cnt));
                cnt++;
                if (cnt == 3) begin
                    exp_q.push_back({has_last && (i == n - 1), acc});
                    tag_q.push_back(tag);
                    acc = '0;
                    cnt = 0;
                end
            end
        end
        if (has_last) begin
            if (sparse) begin
                exp_q.push_back({1'b1, pend ? pw : 32'h0});
                tag_q.push_back(tag);
            end else if (cnt > 0) begin
                exp_q.push_back({1'b1, acc});
                tag_q.push_back(tag);
            end
        end
        // drive
        cfg_sparse = sparse;
        cfg_thr    = 10'(thr);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_amp   = 10'(amp_of(seed, i, thr));
            in_idx   = 14'((first_idx + i) % 16384);
            in_sof   = (i == 0);
            in_last  = has_last && (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            if (flip_cfg && i == 0) begin
                cfg_sparse = !sparse;
                cfg_thr    = 10'((thr + 300) % 1024);
            end
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_last  = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0 words pending", exp_q.size());
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_eoe && in_ready, "R1 reset state",
              {30'b0, out_valid, out_eoe, in_ready}, 33'b1);
        for (int pass = 0; pass < 2; pass++) begin
            bp_en = (pass == 1);
            run_event(1'b1, 100, 9, 16380, 3, 1'b1, 1'b0, "R2 R3 R6 sparse held-back last");
            run_event(1'b1, 200, 10, 500, 5, 1'b1, 1'b0, "R6 sparse kept last with pending");
            run_event(1'b1, 0, 8, 40, 7, 1'b1, 1'b0, "R2 threshold zero");
            run_event(1'b1, 1023, 5, 900, 9, 1'b1, 1'b0, "R7 empty sparse event");
            run_event(1'b0, 50, 6, 0, 11, 1'b1, 1'b0, "R4 dense full words");
            run_event(1'b0, 77, 7, 0, 13, 1'b1, 1'b0, "R5 dense partial flush");
            run_event(1'b1, 500, 8, 1234, 15, 1'b1, 1'b1, "R9 sparse cfg change ignored");
            run_event(1'b0, 10, 5, 0, 17, 1'b1, 1'b1, "R9 dense cfg change ignored");
            run_event(1'b0, 60, 2, 0, 19, 1'b0, 1'b0, "R10 dense unfinished");
            run_event(1'b0, 60, 4, 0, 21, 1'b1, 1'b0, "R10 dense after unfinished");
            run_event(1'b1, 100, 3, 70, 23, 1'b0, 1'b0, "R10 sparse unfinished");
            run_event(1'b1, 100, 6, 80, 25, 1'b1, 1'b0, "R10 sparse after unfinished");
        end
        for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8 no word lost", 33'(exp_q.size()), 33'd0);
        report();
    end
endmodule